// File: doc/BRIEF.md
# Masked Alarm Match Interrupt Unit

This unit watches the running calendar time and signals an alarm when it agrees with a programmed alarm time. Six alarm bytes are provided: seconds, minutes, hours, date, month and day of week. Each byte carries its own compare-enable bit. A field whose enable is clear is left out of the comparison. The comparison is taken once per 1 Hz tick. A match sets a sticky status flag and pulls the active-low interrupt request low.

Two interrupt modes are available. In single-event mode the request stays low for as long as the flag stays set. In recurring pulsed mode every matching tick drives the request low for a fixed pulse. The pulse length is a count of a slower pulse time base, for example four ticks of a 16 Hz strobe for 250 ms. Software clears the flag with a clear strobe. As an alternative, an auto-reset option clears it after a status read. While the shared interrupt pin is carrying a frequency output, the alarm is suppressed.

Top module: `alarm_irq_unit`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `alm_flag` is 0 and `irq_n` is 1.
- R2: Field i of `cur_time` is bits [7i+6:7i], and field i of `alm_regs` is byte [8i+7:8i]. The field order from i=0 is seconds, minutes, hours, date, month, day of week. Bit 7 of an alarm byte enables that field, and bits 6:0 are compared with the time field. A match requires every enabled field to be equal. Disabled fields are ignored.
- R3: The match is evaluated only at a clock edge where `sec_tick` is 1. The flag is visible from that edge on. A standing match without a tick sets nothing.
- R4: With `alm_en` at 0, no match sets the flag or lowers `irq_n`.
- R5: In single-event mode (`pulse_mode`=0), `irq_n` is low exactly while `alm_flag` is 1.
- R6: `stat_clr` high at an edge clears the flag at that edge.
- R7: With `auto_clr`=1, a `stat_rd` strobe at edge k clears the flag at edge k+1. With `auto_clr`=0, a read leaves the flag set.
- R8: In pulsed mode (`pulse_mode`=1), each match sets the flag and drives `irq_n` low from the firing edge until PULSE_TICKS further `pulse_tick` edges have passed. A later matching tick fires again.
- R9: While `fout_active` is 1, no match fires and `irq_n` is held at 1.
- R10: A match and a clear (`stat_clr` or a pending auto-reset) at the same edge leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe each second |
| pulse_tick | input | 1 | One-cycle strobe of the pulse time base |
| cur_time | input | 42 | Six 7-bit BCD time fields |
| alm_regs | input | 48 | Six alarm bytes, bit 7 = field enable |
| alm_en | input | 1 | Alarm master enable |
| pulse_mode | input | 1 | 0 = single event, 1 = recurring pulse |
| auto_clr | input | 1 | Clear flag after status read |
| fout_active | input | 1 | Frequency output owns the interrupt pin |
| stat_rd | input | 1 | Status read strobe |
| stat_clr | input | 1 | Software clear strobe |
| irq_n | output | 1 | Active-low interrupt request |
| alm_flag | output | 1 | Sticky alarm status |

## Verification
A firing tick at edge k shows on `alm_flag` and `irq_n` right after edge k. A clear strobe takes effect at its own edge. An auto-reset read takes effect one edge later. In pulsed mode the request rises at the edge that samples the last counted `pulse_tick`. `fout_active` masks `irq_n` combinationally within the same cycle. The bench changes inputs just after a rising edge. A reference model records the expected outputs for that cycle in a queue, and a monitor compares them 15 ns later, before the next edge.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NFIELDS  = 6;
  localparam int VAL_W    = 7;
  localparam int ALM_W    = VAL_W + 1;
  localparam int TIME_W   = NFIELDS * VAL_W;
  localparam int ALMREG_W = NFIELDS * ALM_W;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W-1:0] cur_val,
  input  logic [VAL_W:0]   alm_byte,
  output logic             hit
);
  logic fld_en;
  logic same;

  always_comb begin
    fld_en = alm_byte[VAL_W];
    same   = (alm_byte[VAL_W-1:0] == cur_val);
    hit    = !fld_en || same;
  end
endmodule

// File: rtl/alarm_pulse_timer.sv
module alarm_pulse_timer #(
  parameter int PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_en;

  always_comb begin
    active = (cnt_q != '0);
    cnt_en = load || (step && active);
    if (load) cnt_nx = CNT_W'(PULSE_TICKS);
    else      cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic sw_clr,
  input  logic rd,
  input  logic auto_clr,
  output logic flag
);
  logic flag_q, flag_nx;
  logic pend_q, pend_nx;

  always_comb begin
    pend_nx = rd && auto_clr;
    flag_nx = set || (flag_q && !sw_clr && !pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      pend_q <= pend_nx;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_tick,
  input  logic                pulse_tick,
  input  logic [TIME_W-1:0]   cur_time,
  input  logic [ALMREG_W-1:0] alm_regs,
  input  logic                alm_en,
  input  logic                pulse_mode,
  input  logic                auto_clr,
  input  logic                fout_active,
  input  logic                stat_rd,
  input  logic                stat_clr,
  output logic                irq_n,
  output logic                alm_flag
);
  logic [NFIELDS-1:0] fld_hit;
  logic               all_hit;
  logic               fire;
  logic               pulse_on;

  for (genvar i = 0; i < NFIELDS; i++) begin : g_fld
    alarm_field_cmp #(.VAL_W(VAL_W)) u_cmp (
      .cur_val  (cur_time[i*VAL_W +: VAL_W]),
      .alm_byte (alm_regs[i*ALM_W +: ALM_W]),
      .hit      (fld_hit[i])
    );
  end

  always_comb begin
    all_hit = &fld_hit;
    fire    = sec_tick && alm_en && !fout_active && all_hit;
  end

  alarm_flag_ctl u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (fire),
    .sw_clr   (stat_clr),
    .rd       (stat_rd),
    .auto_clr (auto_clr),
    .flag     (alm_flag)
  );

  alarm_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (fire && pulse_mode),
    .step   (pulse_tick),
    .active (pulse_on)
  );

  always_comb begin
    if (fout_active)     irq_n = 1'b1;
    else if (pulse_mode) irq_n = !pulse_on;
    else                 irq_n = !alm_flag;
  end
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic alm_en,
  input logic auto_clr,
  input logic fout_active,
  input logic stat_rd,
  input logic stat_clr,
  input logic irq_n,
  input logic alm_flag
);
  // R3
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(sec_tick && alm_en && !fout_active));

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !sec_tick) |=> !alm_flag);

  // R7
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && auto_clr) ##1 !sec_tick |=> !alm_flag);

  // R9
  fout_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fout_active |-> irq_n);

  // R9
  fout_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fout_active && !alm_flag) |=> !alm_flag);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !stat_clr && !stat_rd && !auto_clr && !$past(stat_rd && auto_clr))
      |=> alm_flag);
endmodule

bind alarm_irq_unit alarm_irq_chk u_chk (.*);

// File: tb/alarm_irq_unit_tb.sv
`timescale 1ns/1ps
module alarm_irq_unit_tb;
  localparam int P = 4;

  typedef struct {
    logic   irq_n;
    logic   flag;
    string  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick, pulse_tick, alm_en, pulse_mode, auto_clr;
  logic        fout_active, stat_rd, stat_clr;
  logic [41:0] cur_time;
  logic [47:0] alm_regs;
  logic        irq_n, alm_flag;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  exp_t  q[$];

  logic m_flag, m_pend;
  int   m_cnt;

  always #10 clk = ~clk;

  alarm_irq_unit #(.PULSE_TICKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pulse_tick(pulse_tick),
    .cur_time(cur_time), .alm_regs(alm_regs), .alm_en(alm_en),
    .pulse_mode(pulse_mode), .auto_clr(auto_clr), .fout_active(fout_active),
    .stat_rd(stat_rd), .stat_clr(stat_clr), .irq_n(irq_n), .alm_flag(alm_flag)
  );

  function automatic bit fields_match();
    for (int i = 0; i < 6; i++)
      if (alm_regs[i*8+7] && (alm_regs[i*8 +: 7] != cur_time[i*7 +: 7])) return 1'b0;
    return 1'b1;
  endfunction

  // monitor: compares queued expectations 15 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #15;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (irq_n !== e.irq_n || alm_flag !== e.flag) begin
          n_err++;
          $display("FAIL %s: irq_n=%b alm_flag=%b expected irq_n=%b alm_flag=%b",
                   e.req, irq_n, alm_flag, e.irq_n, e.flag);
        end
      end
    end
  end

  // driver: push expectation for this cycle, then advance model over the edge
  task automatic cyc();
    exp_t e;
    bit   fire;
    e.flag  = m_flag;
    e.irq_n = fout_active ? 1'b1 : (pulse_mode ? (m_cnt == 0) : !m_flag);
    e.req   = cur_req;
    q.push_back(e);
    fire = sec_tick && alm_en && !fout_active && fields_match();
    @(posedge clk);
    m_flag = fire || (m_flag && !stat_clr && !m_pend);
    m_pend = stat_rd && auto_clr;
    if (fire && pulse_mode)          m_cnt = P;
    else if (pulse_tick && m_cnt > 0) m_cnt = m_cnt - 1;
    #2;
  endtask

  task automatic tick_sec();
    sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
  endtask

  task automatic sw_clear();
    stat_clr = 1'b1; cyc(); stat_clr = 1'b0; cyc();
  endtask

  // watchdog
  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 0; pulse_tick = 0; alm_en = 0; pulse_mode = 0;
    auto_clr = 0; fout_active = 0; stat_rd = 0; stat_clr = 0;
    cur_time = '0; alm_regs = '0;
    m_flag = 0; m_pend = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #5;
    n_chk++;
    if (irq_n !== 1'b1 || alm_flag !== 1'b0) begin
      n_err++;
      $display("FAIL R1: irq_n=%b alm_flag=%b expected irq_n=1 alm_flag=0", irq_n, alm_flag);
    end
    @(posedge clk); #2; rst_n = 1'b1;
    cur_req = "R1"; cyc(); cyc();

    // R2: only seconds enabled, other bytes hold mismatching values
    cur_time = {7'h03, 7'h06, 7'h21, 7'h09, 7'h15, 7'h30};
    alm_en = 1'b1;
    cur_req = "R2";
    alm_regs = {8'h05, 8'h11, 8'h02, 8'h22, 8'h44, 8'hB0};
    tick_sec(); cyc();
    cur_req = "R5"; cyc(); cyc();
    cur_req = "R6"; sw_clear();

    // R2: all fields enabled and equal
    cur_req = "R2";
    alm_regs = {8'h83, 8'h86, 8'hA1, 8'h89, 8'h95, 8'hB0};
    tick_sec(); cyc();
    sw_clear();
    // R2: one enabled field differs
    alm_regs = {8'h83, 8'h87, 8'hA1, 8'h89, 8'h95, 8'hB0};
    tick_sec(); cyc(); cyc();

    // R3: standing match without tick sets nothing, then tick fires
    cur_req = "R3";
    alm_regs = {8'h83, 8'h86, 8'hA1, 8'h89, 8'h95, 8'hB0};
    repeat (4) cyc();
    tick_sec(); cyc();

    // R10: fire and clear at the same edge
    cur_req = "R10";
    stat_clr = 1'b1; sec_tick = 1'b1; cyc();
    stat_clr = 1'b0; sec_tick = 1'b0; cyc(); cyc();

    // R7: read without auto-reset keeps flag; with auto-reset clears later
    cur_req = "R7";
    stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    repeat (3) cyc();
    auto_clr = 1'b1;
    stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    repeat (3) cyc();
    // R10: pending auto-reset and a new match at the same edge
    cur_req = "R10";
    tick_sec();
    stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    tick_sec(); cyc(); cyc();
    auto_clr = 1'b0;
    sw_clear();

    // R4: master enable off
    cur_req = "R4";
    alm_en = 1'b0;
    tick_sec(); cyc(); cyc();
    alm_en = 1'b1;

    // R9: frequency output blocks firing and masks the request
    cur_req = "R9";
    fout_active = 1'b1;
    tick_sec(); cyc(); cyc();
    fout_active = 1'b0; cyc();
    tick_sec();
    fout_active = 1'b1; cyc(); cyc();
    fout_active = 1'b0; cyc();
    sw_clear();

    // R8: pulsed recurring mode, seconds-only alarm
    cur_req = "R8";
    pulse_mode = 1'b1;
    alm_regs = {8'h05, 8'h11, 8'h02, 8'h22, 8'h44, 8'hB0};
    tick_sec(); cyc();
    for (int k = 0; k < P + 1; k++) begin
      pulse_tick = 1'b1; cyc(); pulse_tick = 1'b0; cyc(); cyc();
    end
    sw_clear();
    cur_time[6:0] = 7'h31;
    tick_sec(); cyc();
    cur_time[6:0] = 7'h30;
    tick_sec(); cyc();
    pulse_tick = 1'b1; cyc(); pulse_tick = 1'b0;
    tick_sec();
    for (int k = 0; k < P + 1; k++) begin
      pulse_tick = 1'b1; cyc(); pulse_tick = 1'b0; cyc();
    end
    pulse_mode = 1'b0;
    sw_clear();
    cyc(); cyc();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule